// File: doc/BRIEF.md
# RTC BCD Alarm Comparator

This block watches the running time and date of a real-time clock and raises an alarm when the time agrees with a programmed alarm setting. Six one-byte alarm registers cover seconds, minutes, hours, weekday, day of month and month. Each register carries its own compare-enable bit next to a two-digit BCD value. A two-byte year alarm takes part in the comparison when a separate year-enable bit in the control register is set. The alarm condition is met when every enabled field equals its counter, and at least one field must be enabled.

Software programs the registers through a plain write/read port. Reads are combinational. The BCD counters come in as inputs from a counter chain outside this block. A match condition that starts sets a sticky alarm flag once. The flag stays set until software writes 0 to it. The interrupt output is the flag gated by an interrupt-enable bit.

There are two reset inputs. The power-on reset clears every compare enable. The manual reset leaves all enables in place. Neither reset touches the stored BCD values.

Top module: `rtc_alarm_cmp`

## Requirements
- R1: Field alarm registers sit at addresses 0 (seconds), 1 (minutes), 2 (hours), 3 (weekday), 4 (day) and 5 (month). In each one, bit 7 is the compare enable, bits 6:4 are the BCD tens digit and bits 3:0 are the BCD ones digit. A read returns exactly the byte that was last written.
- R2: The year alarm occupies address 6 (low two BCD digits) and address 7 (high two BCD digits). When year-enable is set, all 16 bits are compared with the year counter.
- R3: Control register at address 8: bit 0 is the alarm flag, bit 1 is interrupt-enable and bit 2 is year-enable. Unused bits read 0.
- R4: Power-on reset clears every field enable bit, year-enable, interrupt-enable and the flag. It does not change any stored BCD value.
- R5: Manual reset clears the flag and interrupt-enable. It leaves the field enable bits, year-enable and all BCD values unchanged.
- R6: The match condition holds when every enabled field equals its counter. Fields that are disabled have no effect on the result.
- R7: When no field is enabled and year-enable is 0, the flag never sets.
- R8: The flag sets only on the cycle after the match condition goes from false to true. While the match stays true, the flag does not set again.
- R9: Writing the control register with bit 0 = 0 clears the flag. Writing bit 0 = 1 leaves the flag unchanged.
- R10: The interrupt output is high exactly when the flag and interrupt-enable are both 1.
- R11: Out-of-range codes (for example seconds 0x7F) are stored unchanged and compared bit for bit.
- R12: If a new match starts in the same cycle that software clears the flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst_n | input | 1 | Manual reset, asynchronous, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| cnt_sec | input | 7 | BCD seconds counter |
| cnt_min | input | 7 | BCD minutes counter |
| cnt_hour | input | 7 | BCD hours counter |
| cnt_wday | input | 7 | Weekday counter |
| cnt_day | input | 7 | BCD day-of-month counter |
| cnt_mon | input | 7 | BCD month counter |
| cnt_year | input | 16 | Four-digit BCD year counter |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq | output | 1 | Alarm interrupt |

## Verification
Two things can land on the same clock edge: a new match that sets the flag, and a software write that clears it. The bench first sets the flag and moves the counters away from the alarm time. On one falling edge it then drives the counters back to the alarm time and issues a clear write. After the next rising edge the flag must read 1. One cycle later, with the match still true, a second clear must leave the flag at 0. This shows that set has priority only on the start of a match and does not keep re-asserting the flag.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int REG_W      = 8;
  localparam int VAL_W      = REG_W - 1;
  localparam int ADDR_W     = 4;
  localparam int NUM_FIELDS = 6;
  localparam int YEAR_W     = 16;

  localparam logic [ADDR_W-1:0] ADR_YLO = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_YHI = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_CTL = 4'd8;

  localparam int CTL_FLAG = 0;
  localparam int CTL_IE   = 1;
  localparam int CTL_YEN  = 2;
  localparam int CTL_W    = 3;
endpackage

// File: rtl/rtc_alarm_field.sv
module rtc_alarm_field #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [W-2:0] cnt,
  output logic [W-1:0] rdata,
  output logic         en,
  output logic         hit
);
  localparam int VW = W - 1;

  logic          en_q, en_d;
  logic [VW-1:0] val_q, val_d;

  always_comb begin
    en_d  = we ? wdata[VW]     : en_q;
    val_d = we ? wdata[VW-1:0] : val_q;
  end

  // compare enable: cleared only by power-on reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  // BCD value: no reset at all, held through every reset
  always_ff @(posedge clk) begin
    if (we) val_q <= val_d;
  end

  assign rdata = {en_q, val_q};
  assign en    = en_q;
  assign hit   = (val_q == cnt);
endmodule

// File: rtl/rtc_alarm_year.sv
module rtc_alarm_year #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic [DW/8-1:0] we,
  input  logic [7:0]      wdata,
  input  logic [DW-1:0]   cnt,
  output logic [DW-1:0]   value,
  output logic            hit
);
  localparam int NB = DW / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [7:0] byte_q, byte_d;
    always_comb byte_d = we[b] ? wdata : byte_q;
    always_ff @(posedge clk) begin
      if (we[b]) byte_q <= byte_d;
    end
    assign value[8*b +: 8] = byte_q;
  end

  assign hit = (value == cnt);
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             mrst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             match_all,
  output logic             flag,
  output logic             ie,
  output logic             yen,
  output logic             irq
);
  logic rst_any_n;
  logic flag_q, flag_d, ie_q, ie_d, yen_q, yen_d, match_q;
  logic set_ev, clr_ev;

  assign rst_any_n = por_n & mrst_n;

  always_comb begin
    set_ev = match_all & ~match_q;
    clr_ev = ctl_we & ~ctl_wdata[CTL_FLAG];
    flag_d = set_ev | (flag_q & ~clr_ev);
    ie_d   = ctl_we ? ctl_wdata[CTL_IE]  : ie_q;
    yen_d  = ctl_we ? ctl_wdata[CTL_YEN] : yen_q;
  end

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n) begin
      flag_q  <= 1'b0;
      ie_q    <= 1'b0;
      match_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      ie_q    <= ie_d;
      match_q <= match_all;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) yen_q <= 1'b0;
    else        yen_q <= yen_d;
  end

  assign flag = flag_q;
  assign ie   = ie_q;
  assign yen  = yen_q;
  assign irq  = flag_q & ie_q;
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              mrst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [VAL_W-1:0]  cnt_sec,
  input  logic [VAL_W-1:0]  cnt_min,
  input  logic [VAL_W-1:0]  cnt_hour,
  input  logic [VAL_W-1:0]  cnt_wday,
  input  logic [VAL_W-1:0]  cnt_day,
  input  logic [VAL_W-1:0]  cnt_mon,
  input  logic [YEAR_W-1:0] cnt_year,
  output logic              alarm_flag,
  output logic              irq
);
  localparam int YB = YEAR_W / 8;

  logic [VAL_W-1:0]      cnt_arr [NUM_FIELDS];
  logic [REG_W-1:0]      fld_rd  [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] en_vec, hit_vec, ok_vec;
  logic [YEAR_W-1:0]     year_val;
  logic [YB-1:0]         year_we;
  logic                  year_hit, year_en, year_ok, any_en, match_all;
  logic                  ctl_we, ie;

  assign cnt_arr[0] = cnt_sec;
  assign cnt_arr[1] = cnt_min;
  assign cnt_arr[2] = cnt_hour;
  assign cnt_arr[3] = cnt_wday;
  assign cnt_arr[4] = cnt_day;
  assign cnt_arr[5] = cnt_mon;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    logic f_we;
    assign f_we = reg_we && (reg_addr == ADDR_W'(i));
    rtc_alarm_field #(.W(REG_W)) u_fld (
      .clk   (clk),
      .por_n (por_n),
      .we    (f_we),
      .wdata (reg_wdata),
      .cnt   (cnt_arr[i]),
      .rdata (fld_rd[i]),
      .en    (en_vec[i]),
      .hit   (hit_vec[i])
    );
  end

  assign year_we[0] = reg_we && (reg_addr == ADR_YLO);
  assign year_we[1] = reg_we && (reg_addr == ADR_YHI);
  assign ctl_we     = reg_we && (reg_addr == ADR_CTL);

  rtc_alarm_year #(.DW(YEAR_W)) u_year (
    .clk   (clk),
    .we    (year_we),
    .wdata (reg_wdata),
    .cnt   (cnt_year),
    .value (year_val),
    .hit   (year_hit)
  );

  always_comb begin
    ok_vec    = ~en_vec | hit_vec;
    year_ok   = ~year_en | year_hit;
    any_en    = (|en_vec) | year_en;
    match_all = (&ok_vec) & year_ok & any_en;
  end

  rtc_alarm_irq u_irq (
    .clk       (clk),
    .por_n     (por_n),
    .mrst_n    (mrst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (reg_wdata[CTL_W-1:0]),
    .match_all (match_all),
    .flag      (alarm_flag),
    .ie        (ie),
    .yen       (year_en),
    .irq       (irq)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (reg_addr == ADDR_W'(i)) reg_rdata = fld_rd[i];
    end
    if (reg_addr == ADR_YLO) reg_rdata = year_val[7:0];
    if (reg_addr == ADR_YHI) reg_rdata = year_val[15:8];
    if (reg_addr == ADR_CTL) reg_rdata = {{(REG_W-CTL_W){1'b0}}, year_en, ie, alarm_flag};
  end
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk
  import rtc_alarm_pkg::*;
(
  input logic                  clk,
  input logic                  por_n,
  input logic                  mrst_n,
  input logic                  reg_we,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic                  wbit0,
  input logic                  alarm_flag,
  input logic                  irq,
  input logic [NUM_FIELDS-1:0] en_vec,
  input logic                  year_en,
  input logic                  match_all
);
  AST_FLAG_FROM_MATCH: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
    $rose(alarm_flag) |-> $past(match_all)); // R8

  AST_NONE_ENABLED: assert property (@(posedge clk) disable iff (!por_n)
    (en_vec == '0 && !year_en) |-> !match_all); // R7

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!por_n)
    irq |-> alarm_flag); // R10

  AST_EN_KEEP_MRST: assert property (@(posedge clk) disable iff (!por_n)
    (!mrst_n && !reg_we) |=> $stable(en_vec) && $stable(year_en)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
    (alarm_flag && !(reg_we && reg_addr == ADR_CTL && !wbit0)) |=> alarm_flag); // R9
endmodule

bind rtc_alarm_cmp rtc_alarm_chk u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .mrst_n     (mrst_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .wbit0      (reg_wdata[0]),
  .alarm_flag (alarm_flag),
  .irq        (irq),
  .en_vec     (en_vec),
  .year_en    (year_en),
  .match_all  (match_all)
);

// File: tb/sim_rtc_alarm_cmp.sv
module sim_rtc_alarm_cmp;
  logic        clk = 1'b0;
  logic        por_n, mrst_n, reg_we;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [6:0]  cnt_sec, cnt_min, cnt_hour, cnt_wday, cnt_day, cnt_mon;
  logic [15:0] cnt_year;
  logic        alarm_flag, irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_alarm_cmp u0 (.*);

  typedef struct packed {
    logic [6:0]  s, m, h, w, d, mo;
    logic [15:0] y;
    logic        exp;
  } vec_t;

  // alarm: sec 30, min 15, day 07 enabled; hour/wday/month disabled
  localparam vec_t VEC [7] = '{
    '{7'h30, 7'h15, 7'h12, 7'h03, 7'h07, 7'h11, 16'h0000, 1'b1},
    '{7'h31, 7'h15, 7'h12, 7'h03, 7'h07, 7'h11, 16'h0000, 1'b0},
    '{7'h30, 7'h16, 7'h12, 7'h03, 7'h07, 7'h11, 16'h0000, 1'b0},
    '{7'h30, 7'h15, 7'h12, 7'h03, 7'h08, 7'h11, 16'h0000, 1'b0},
    '{7'h30, 7'h15, 7'h23, 7'h06, 7'h07, 7'h12, 16'h1999, 1'b1},
    '{7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 16'h0000, 1'b0},
    '{7'h30, 7'h15, 7'h00, 7'h00, 7'h07, 7'h00, 16'h2024, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic setcnt(input logic [6:0] s, m, h, w, d, mo, input logic [15:0] y);
    cnt_sec = s; cnt_min = m; cnt_hour = h; cnt_wday = w; cnt_day = d; cnt_mon = mo; cnt_year = y;
  endtask

  // neutral counts plus control write, then the vector; returns one edge later
  task automatic apply(input logic [6:0] s, m, h, w, d, mo, input logic [15:0] y, input logic [7:0] ctl);
    @(negedge clk);
    setcnt(7'h59, 7'h59, 7'h00, 7'h00, 7'h00, 7'h00, 16'h0000);
    reg_we = 1'b1; reg_addr = 4'd8; reg_wdata = ctl;
    @(negedge clk);
    reg_we = 1'b0;
    setcnt(s, m, h, w, d, mo, y);
    @(negedge clk);
  endtask

  task automatic program_std();
    wr(4'd0, 8'hB0); wr(4'd1, 8'h95); wr(4'd2, 8'h12);
    wr(4'd3, 8'h03); wr(4'd4, 8'h87); wr(4'd5, 8'h11);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    por_n = 1'b0; mrst_n = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    setcnt(7'h59, 7'h59, 7'h00, 7'h00, 7'h00, 7'h00, 16'h0000);
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(4'd8, r);
    check(r == 8'h00, "R4 ctl after power-on", {8'h0, r}, 16'h0000);
    check(irq == 1'b0 && alarm_flag == 1'b0, "R10 irq after power-on", {14'h0, alarm_flag, irq}, 16'h0);
    rd(4'd0, r);
    check(r[7] == 1'b0, "R4 sec enable after power-on", {15'h0, r[7]}, 16'h0);

    // register readback
    program_std();
    wr(4'd6, 8'h24); wr(4'd7, 8'h20);
    rd(4'd1, r); check(r == 8'h95, "R1 minute readback", {8'h0, r}, 16'h0095);
    rd(4'd4, r); check(r == 8'h87, "R1 day readback", {8'h0, r}, 16'h0087);
    rd(4'd7, r); check(r == 8'h20, "R2 year high readback", {8'h0, r}, 16'h0020);

    // table walk
    foreach (VEC[i]) begin
      apply(VEC[i].s, VEC[i].m, VEC[i].h, VEC[i].w, VEC[i].d, VEC[i].mo, VEC[i].y, 8'h02);
      check(alarm_flag == VEC[i].exp, $sformatf("R6 vector %0d flag", i), {15'h0, alarm_flag}, {15'h0, VEC[i].exp});
      check(irq == VEC[i].exp, $sformatf("R10 vector %0d irq", i), {15'h0, irq}, {15'h0, VEC[i].exp});
    end

    // interrupt gated off
    apply(7'h30, 7'h15, 7'h12, 7'h03, 7'h07, 7'h11, 16'h0, 8'h00);
    check(alarm_flag == 1'b1 && irq == 1'b0, "R10 ie=0 masks irq", {14'h0, alarm_flag, irq}, 16'h0002);

    // year compare
    apply(7'h30, 7'h15, 7'h12, 7'h03, 7'h07, 7'h11, 16'h2023, 8'h06);
    check(alarm_flag == 1'b0, "R2 year mismatch", {15'h0, alarm_flag}, 16'h0);
    apply(7'h30, 7'h15, 7'h12, 7'h03, 7'h07, 7'h11, 16'h2024, 8'h06);
    check(alarm_flag == 1'b1, "R2 year match", {15'h0, alarm_flag}, 16'h1);

    // R12 collision: set the flag, leave match, then new match with clear in same cycle
    apply(7'h30, 7'h15, 7'h00, 7'h00, 7'h07, 7'h00, 16'h0, 8'h02);
    setcnt(7'h59, 7'h15, 7'h00, 7'h00, 7'h07, 7'h00, 16'h0);
    @(negedge clk);
    check(alarm_flag == 1'b1, "R9 flag held without write", {15'h0, alarm_flag}, 16'h1);
    setcnt(7'h30, 7'h15, 7'h00, 7'h00, 7'h07, 7'h00, 16'h0);
    reg_we = 1'b1; reg_addr = 4'd8; reg_wdata = 8'h02;
    @(negedge clk);
    reg_we = 1'b0;
    check(alarm_flag == 1'b1, "R12 set beats clear", {15'h0, alarm_flag}, 16'h1);
    wr(4'd8, 8'h03);
    check(alarm_flag == 1'b1, "R9 write 1 keeps flag", {15'h0, alarm_flag}, 16'h1);
    wr(4'd8, 8'h02);
    check(alarm_flag == 1'b0, "R9 write 0 clears flag", {15'h0, alarm_flag}, 16'h0);
    repeat (3) @(negedge clk);
    check(alarm_flag == 1'b0, "R8 no re-set while match holds", {15'h0, alarm_flag}, 16'h0);

    // out-of-range code
    wr(4'd0, 8'hFF);
    rd(4'd0, r); check(r == 8'hFF, "R11 raw code readback", {8'h0, r}, 16'h00FF);
    apply(7'h7F, 7'h15, 7'h00, 7'h00, 7'h07, 7'h00, 16'h0, 8'h02);
    check(alarm_flag == 1'b1, "R11 raw code match", {15'h0, alarm_flag}, 16'h1);

    // nothing enabled
    wr(4'd0, 8'h30); wr(4'd1, 8'h15); wr(4'd4, 8'h07);
    apply(7'h30, 7'h15, 7'h12, 7'h03, 7'h07, 7'h11, 16'h0, 8'h02);
    check(alarm_flag == 1'b0, "R7 no enable no alarm", {15'h0, alarm_flag}, 16'h0);

    // manual reset
    program_std();
    apply(7'h30, 7'h15, 7'h12, 7'h03, 7'h07, 7'h11, 16'h2024, 8'h06);
    check(alarm_flag == 1'b1, "R5 flag set before manual reset", {15'h0, alarm_flag}, 16'h1);
    setcnt(7'h59, 7'h59, 7'h00, 7'h00, 7'h00, 7'h00, 16'h0);
    mrst_n = 1'b0;
    @(negedge clk);
    mrst_n = 1'b1;
    @(negedge clk);
    rd(4'd8, r); check(r == 8'h04, "R5 ctl after manual reset", {8'h0, r}, 16'h0004);
    rd(4'd0, r); check(r == 8'hB0, "R5 sec kept by manual reset", {8'h0, r}, 16'h00B0);
    rd(4'd4, r); check(r == 8'h87, "R5 day kept by manual reset", {8'h0, r}, 16'h0087);

    // power-on reset
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    rd(4'd0, r); check(r == 8'h30, "R4 sec value kept, enable cleared", {8'h0, r}, 16'h0030);
    rd(4'd4, r); check(r == 8'h07, "R4 day value kept, enable cleared", {8'h0, r}, 16'h0007);
    rd(4'd6, r); check(r == 8'h24, "R4 year value kept", {8'h0, r}, 16'h0024);
    rd(4'd8, r); check(r == 8'h00, "R3 ctl cleared by power-on", {8'h0, r}, 16'h0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule